// File: doc/BRIEF.md
# System Configuration Register Bank

This block is a bank of 32-bit configuration and status words reached through a plain memory-mapped port. The port carries a byte address, a write strobe with write data and a read strobe. The bank holds 192 words, and the word index is taken from the byte address with its two low bits dropped. The block stores values only. Nothing it holds drives remapping, PLL hardware or clock generation.

Most words are plain storage that reset to zero. A few words have fixed behaviour:

- A PLL configuration word and a clock-divider word take non-zero values at reset.
- The clock-divider reset value is built from two bus clock divisor parameters. Each divisor is a power of two, and each is turned into a 3-bit code.
- A PLL lock-status word cannot be written.
- Three remap-control words refuse every write. A write whose data differs from the stored value raises a one-cycle "unsupported" pulse.
- An access at or beyond the end of the window is dropped. A read there returns zero, and either kind of access raises a one-cycle address-error pulse.

Both divisor parameters are checked at elaboration.

Top module: `cfg_regbank`

## Requirements
- R1: The word index is byte address bits [ADDR_W-1:2]. Address bits [1:0] have no effect on which word is read or written.
- R2: After reset, the following words read as listed:

  | Word | Byte offset | Reset value |
  |------|-------------|-------------|
  | 36 | 0x90 | 0x021A2358 |
  | 84 | 0x150 | 0x00000003 |
  | 38 | 0x98 | divisor codes, see R3 |
  | every other word | | 0 |

- R3: The reset value of word 38 is code(DIV_A) in bits [7:5] and code(DIV_B) in bits [4:2], with every other bit zero. The code maps divisors 1, 2, 4, 8, 16 and 32 to 0, 1, 2, 4, 5 and 6. With both divisors at their default of 2, the value is 0x24. With DIV_A=32 and DIV_B=8, it is 0xD0.
- R4: DIV_A and DIV_B must each be a power of two no greater than 32. Any other value stops elaboration with an error.
- R5: A write to any in-range word that is not listed in R6 or R7 stores all 32 bits, and later reads return that value.
- R6: Writes to word 84 (byte offset 0x150) are ignored, and the word always reads 0x3.
- R7: Writes to words 0, 2 and 4 (byte offsets 0x00, 0x08 and 0x10) never change them, so they keep reading 0. Such a write raises unsup_pulse exactly when the write data differs from the stored value.
- R8: An access with word index 192 or above writes nothing and reads back zero. Any read or write there raises addr_err.
- R9: rd_data shows the addressed word in the cycle after the clock edge that samples rd_en. It holds that value until the next read. rd_data reads 0 after reset. unsup_pulse and addr_err are high for exactly the one cycle after the edge that samples the access.
- R10: When a read and a write hit the same word on the same edge, the read returns the value stored before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_addr | input | ADDR_W | Byte address of the access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DATA_W | Read data, one cycle after rd_en |
| unsup_pulse | output | 1 | A write to a remap word tried to change it |
| addr_err | output | 1 | The access was at or beyond the window end |

## Verification
A read and a write can land on the same word on the same edge. In that case the read path and the store update compete for one word.

The bench provokes this by driving both strobes with one address whose old and new contents differ. It expects the read to return the old contents and a following read to return the new ones.

Read and write strobes can also both fall outside the window at once. The address-error flag must then be a single pulse, and full sweeps of every in-range and out-of-range index compare each result with values computed from the requirements.

// File: rtl/cfg_regbank_pkg.sv
package cfg_regbank_pkg;

  // Word indices with special behaviour
  localparam int WIDX_PLL_CFG   = 36;  // byte 0x90
  localparam int WIDX_CLKDIV    = 38;  // byte 0x98
  localparam int WIDX_PLL_LOCK  = 84;  // byte 0x150, read-only
  localparam int WIDX_REMAP_A   = 0;   // write-locked
  localparam int WIDX_REMAP_B   = 2;
  localparam int WIDX_REMAP_C   = 4;

  localparam logic [31:0] PLL_CFG_INIT  = 32'h021A_2358;
  localparam logic [31:0] PLL_LOCK_INIT = 32'h0000_0003;

  localparam int CODE_A_LSB = 5;
  localparam int CODE_B_LSB = 2;

  // R4: legal divisor values
  function automatic bit div_is_legal(input int d);
    return (d == 1) || (d == 2) || (d == 4) || (d == 8) || (d == 16) || (d == 32);
  endfunction

  // R3: trailing-zero count, plus one from 8 upward
  function automatic logic [2:0] div_code(input int d);
    int tz;
    tz = 0;
    for (int k = 0; k < 6; k++) begin
      if (d == (1 << k)) tz = k;
    end
    return (d < 8) ? 3'(tz) : 3'(tz + 1);
  endfunction

endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode
  import cfg_regbank_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int WORDS  = 192,
  parameter int IDX_W  = 8
) (
  input  logic [ADDR_W-3:0] word_sel,
  output logic              in_range,
  output logic [IDX_W-1:0]  word_idx,
  output logic              is_ro,
  output logic              is_locked
);

  always_comb begin
    in_range  = (int'(word_sel) < WORDS);
    word_idx  = in_range ? word_sel[IDX_W-1:0] : '0;
    is_ro     = in_range && (word_idx == IDX_W'(WIDX_PLL_LOCK));
    is_locked = in_range && ((word_idx == IDX_W'(WIDX_REMAP_A)) ||
                             (word_idx == IDX_W'(WIDX_REMAP_B)) ||
                             (word_idx == IDX_W'(WIDX_REMAP_C)));
  end

endmodule

// File: rtl/cfg_reset_table.sv
module cfg_reset_table
  import cfg_regbank_pkg::*;
#(
  parameter int DIV_A  = 2,
  parameter int DIV_B  = 2,
  parameter int IDX_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic [IDX_W-1:0]  word_idx,
  output logic [DATA_W-1:0] init_val
);

  localparam logic [2:0] CODE_A = div_code(DIV_A);
  localparam logic [2:0] CODE_B = div_code(DIV_B);
  localparam logic [DATA_W-1:0] CLKDIV_INIT =
    (DATA_W'(CODE_A) << CODE_A_LSB) | (DATA_W'(CODE_B) << CODE_B_LSB);

  always_comb begin
    init_val = '0;
    if (word_idx == IDX_W'(WIDX_PLL_CFG))  init_val = DATA_W'(PLL_CFG_INIT);
    if (word_idx == IDX_W'(WIDX_CLKDIV))   init_val = CLKDIV_INIT;
    if (word_idx == IDX_W'(WIDX_PLL_LOCK)) init_val = DATA_W'(PLL_LOCK_INIT);
  end

endmodule

// File: rtl/cfg_word_store.sv
module cfg_word_store #(
  parameter int WORDS  = 192,
  parameter int IDX_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              re,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata_q,
  output logic              written_q
);

  logic [DATA_W-1:0] mem [WORDS];
  logic [WORDS-1:0]  written;

  // Plain RAM: no reset, read-first (R10)
  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
    if (re) rdata_q  <= mem[idx];
  end

  // Per-word "has been written" bits stand in for a RAM reset
  always_ff @(posedge clk) begin
    if (rst) begin
      written   <= '0;
      written_q <= 1'b0;
    end else begin
      if (re) written_q    <= written[idx];
      if (we) written[idx] <= 1'b1;
    end
  end

endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
  import cfg_regbank_pkg::*;
#(
  parameter int ADDR_W       = 10,
  parameter int DATA_W       = 32,
  parameter int WINDOW_BYTES = 768,
  parameter int DIV_A        = 2,
  parameter int DIV_B        = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              unsup_pulse,
  output logic              addr_err
);

  localparam int WORDS = WINDOW_BYTES / 4;
  localparam int IDX_W = $clog2(WORDS);

  // R4: elaboration-time parameter checks
  if (!div_is_legal(DIV_A) || !div_is_legal(DIV_B)) begin : g_bad_div
    $error("cfg_regbank: DIV_A and DIV_B must be a power of two up to 32");
  end
  if (ADDR_W - 2 < IDX_W) begin : g_bad_addr
    $error("cfg_regbank: ADDR_W too small for WINDOW_BYTES");
  end

  logic              unused_lo;
  logic              in_range, is_ro, is_locked;
  logic [IDX_W-1:0]  word_idx;
  logic [DATA_W-1:0] init_val, ram_q, init_q;
  logic              written_q, rd_ok_q, store_we;

  assign unused_lo = ^acc_addr[1:0];  // R1: byte lanes ignored

  cfg_addr_decode #(.ADDR_W(ADDR_W), .WORDS(WORDS), .IDX_W(IDX_W)) u_dec (
    .word_sel  (acc_addr[ADDR_W-1:2]),
    .in_range  (in_range),
    .word_idx  (word_idx),
    .is_ro     (is_ro),
    .is_locked (is_locked)
  );

  cfg_reset_table #(.DIV_A(DIV_A), .DIV_B(DIV_B), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_init (
    .word_idx (word_idx),
    .init_val (init_val)
  );

  assign store_we = wr_en && in_range && !is_ro && !is_locked;

  cfg_word_store #(.WORDS(WORDS), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_store (
    .clk       (clk),
    .rst       (rst),
    .we        (store_we),
    .re        (rd_en && in_range),
    .idx       (word_idx),
    .wdata     (wr_data),
    .rdata_q   (ram_q),
    .written_q (written_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ok_q     <= 1'b0;
      init_q      <= '0;
      unsup_pulse <= 1'b0;
      addr_err    <= 1'b0;
    end else begin
      if (rd_en) begin
        rd_ok_q <= in_range;
        init_q  <= init_val;
      end
      // a locked word always holds its reset value
      unsup_pulse <= wr_en && is_locked && (wr_data != init_val);
      addr_err    <= (wr_en || rd_en) && !in_range;
    end
  end

  assign rd_data = !rd_ok_q ? '0 : (written_q ? ram_q : init_q);

endmodule

// File: rtl/cfg_regbank_chk.sv
module cfg_regbank_chk
  import cfg_regbank_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int WORDS  = 192
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic              unsup_pulse,
  input logic              addr_err
);

  logic [ADDR_W-3:0] ix;
  logic unused_chk, oor, acc, lockw;
  assign unused_chk = ^acc_addr[1:0];
  assign ix    = acc_addr[ADDR_W-1:2];
  assign oor   = int'(ix) >= WORDS;
  assign acc   = wr_en || rd_en;
  assign lockw = !oor && ((int'(ix) == WIDX_REMAP_A) || (int'(ix) == WIDX_REMAP_B) ||
                          (int'(ix) == WIDX_REMAP_C));

  AST_OOR_FLAGGED: assert property (@(posedge clk) disable iff (rst) acc && oor |=> addr_err); // R8
  AST_ERR_CAUSED: assert property (@(posedge clk) disable iff (rst) !(acc && oor) |=> !addr_err); // R8
  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (rst) rd_en && oor |=> rd_data == '0); // R8
  AST_UNSUP_CAUSED: assert property (@(posedge clk) disable iff (rst) !(wr_en && lockw) |=> !unsup_pulse); // R7
  AST_LOCKED_ZERO: assert property (@(posedge clk) disable iff (rst) rd_en && lockw |=> rd_data == '0); // R7
  AST_PLL_LOCK_FIXED: assert property (@(posedge clk) disable iff (rst)
    rd_en && !oor && int'(ix) == WIDX_PLL_LOCK |=> rd_data == DATA_W'(PLL_LOCK_INIT)); // R6
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst) !rd_en |=> $stable(rd_data)); // R9

endmodule

bind cfg_regbank cfg_regbank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .acc_addr    (acc_addr),
  .wr_en       (wr_en),
  .rd_en       (rd_en),
  .rd_data     (rd_data),
  .unsup_pulse (unsup_pulse),
  .addr_err    (addr_err)
);

// File: tb/tb_cfg_regbank.sv
module tb_cfg_regbank;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  acc_addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data, rd_b;
  logic        unsup_pulse, addr_err, unsup_b, err_b;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  cfg_regbank dut (
    .clk(clk), .rst(rst), .acc_addr(acc_addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .unsup_pulse(unsup_pulse), .addr_err(addr_err)
  );

  cfg_regbank #(.DIV_A(32), .DIV_B(8)) dut_b (
    .clk(clk), .rst(rst), .acc_addr(acc_addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_b), .unsup_pulse(unsup_b), .addr_err(err_b)
  );

  function automatic logic [31:0] pat(input int i);
    return {8'h5A, 8'(i), 8'(~i), 8'h3C};
  endfunction

  function automatic logic [31:0] exp_reset(input int i);
    if (i == 36) return 32'h021A2358;
    if (i == 38) return 32'h24;
    if (i == 84) return 32'h3;
    return 32'h0;
  endfunction

  function automatic bit is_locked(input int i);
    return (i == 0) || (i == 2) || (i == 4);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    acc_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [9:0] a);
    @(negedge clk);
    acc_addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 reset rd_data", rd_data, 32'h0);
    chk("R9 reset addr_err", 32'(addr_err), 32'h0);
    chk("R9 reset unsup_pulse", 32'(unsup_pulse), 32'h0);

    // reset values, low address bits varied
    for (int i = 0; i < 192; i++) begin
      do_read(10'(i * 4 + (i % 4)));
      chk("R1/R2 reset value", rd_data, exp_reset(i));
      if (i == 38) chk("R3/R4 divisor codes 32,8", rd_b, 32'hD0);
      if (i == 0) chk("R8 no addr_err in range", 32'(addr_err), 32'h0);
    end

    // write every in-range word
    for (int i = 0; i < 192; i++) begin
      do_write(10'(i * 4 + ((i + 1) % 4)), pat(i));
      chk("R7 unsup_pulse on write", 32'(unsup_pulse), 32'(is_locked(i)));
      if (i == 7) chk("R5 no addr_err on write", 32'(addr_err), 32'h0);
    end
    do_write(10'h008, 32'h0);
    chk("R7 equal data no pulse", 32'(unsup_pulse), 32'h0);
    do_write(10'h010, 32'h1);
    chk("R7 differing data pulse", 32'(unsup_pulse), 32'h1);
    @(negedge clk);
    chk("R9 pulse one cycle wide", 32'(unsup_pulse), 32'h0);

    // read everything back
    for (int i = 0; i < 192; i++) begin
      logic [31:0] e;
      do_read(10'(i * 4));
      e = (i == 84) ? 32'h3 : (is_locked(i) ? 32'h0 : pat(i));
      if (i == 84) chk("R6 PLL status ignores writes", rd_data, e);
      else if (is_locked(i)) chk("R7 locked word unchanged", rd_data, e);
      else chk("R5 stored word readback", rd_data, e);
    end
    held = rd_data;
    repeat (3) @(negedge clk);
    chk("R9 rd_data holds", rd_data, held);

    // out-of-range sweep
    for (int j = 192; j < 256; j++) begin
      do_write(10'(j * 4), 32'hDEAD0000 | 32'(j));
      chk("R8 addr_err on write", 32'(addr_err), 32'h1);
      do_read(10'(j * 4));
      chk("R8 out-of-range read zero", rd_data, 32'h0);
      chk("R8 addr_err on read", 32'(addr_err), 32'h1);
    end
    @(negedge clk);
    chk("R8 addr_err one cycle", 32'(addr_err), 32'h0);
    do_read(10'h014);
    chk("R8 discarded write touched nothing", rd_data, pat(5));

    // both strobes, out of range, same edge
    @(negedge clk);
    acc_addr = 10'h3F0; wr_en = 1'b1; rd_en = 1'b1; wr_data = 32'h1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R8 dual access addr_err", 32'(addr_err), 32'h1);
    @(negedge clk);
    chk("R8 dual access single pulse", 32'(addr_err), 32'h0);

    // read and write to the same word on one edge
    @(negedge clk);
    acc_addr = 10'h020; wr_en = 1'b1; rd_en = 1'b1; wr_data = 32'h12345678;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R10 read returns old value", rd_data, pat(8));
    do_read(10'h020);
    chk("R10 new value after", rd_data, 32'h12345678);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule